// File: doc/BRIEF.md
# UART Interrupt Mask and Status Register Bank

This block holds the interrupt control registers of a serial port. The receive and transmit datapaths send one-cycle event pulses into it. Each pulse sets a sticky bit in a status register, whatever the mask holds. Software opens and closes the path from each status bit to the single interrupt line through a mask. The mask has no direct write access. It changes only through two write aliases: one sets bits where ones are written, the other clears bits where ones are written. Status bits are cleared by writing ones to the status register.

A separate read-only view gives the live level of four FIFO conditions: receive trigger reached, receive empty, transmit empty and transmit full. This view ignores the mask, so polling software can see those conditions while their interrupts are disabled.

The bus is a simple single-cycle strobe interface. A write takes effect at the clock edge that samples it. A read returns its data on `rd_data` one cycle after the request. The interrupt output is registered and follows the masked status one cycle later.

Top module: `uirq_bank`

## Requirements
- R1: After a synchronous reset, the mask is all zero, the status is all zero, `irq` is 0 and `rd_data` is 0.
- R2: A write to offset 0x08 sets each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged.
- R3: A write to offset 0x0C clears each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged.
- R4: Reads of offsets 0x08 and 0x0C return zero. Offset 0x10 returns the mask, and a write to 0x10 does not change the mask.
- R5: A pulse on `evt[i]` sets status bit i whether or not mask bit i is set, and the bit stays set until cleared. The bit map is: 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout.
- R6: A write to offset 0x14 clears each status bit whose data bit is 1. Data bits of 0 have no effect. Offset 0x14 reads back the status.
- R7: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends set.
- R8: `irq` is 1 exactly when some bit is set in both status and mask, one clock after that state exists.
- R9: A read of offset 0x2C returns the live levels RX trigger (bit 0), RX empty (bit 1), TX empty (bit 3) and TX full (bit 4), independent of the mask. All its other bits read 0.
- R10: Data bits 9 and above are ignored on writes and read as zero from every offset.
- R11: `rd_data` holds the value for a read one cycle after the read strobe. Offsets that are not decoded read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| evt | input | 9 | Event pulses, one bit per interrupt source |
| lv_rx_trig | input | 1 | Live: receive FIFO at or above trigger level |
| lv_rx_empty | input | 1 | Live: receive FIFO empty |
| lv_tx_empty | input | 1 | Live: transmit FIFO empty |
| lv_tx_full | input | 1 | Live: transmit FIFO full |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that:
- a set write leaves the written ones set in the mask, and a clear write leaves them clear;
- every event pulse lands in the status register, including when a clear strikes the same bit;
- clear writes remove only the bits that had no simultaneous event;
- `irq` follows the masked status one cycle behind;
- the upper read bits stay zero.

Only the directed scenarios can show the remaining behaviour:
- writes of zero and writes to the mask offset really leave state untouched;
- the aliases read as zero;
- the raw view tracks the live inputs while every interrupt is masked;
- undecoded offsets return zero.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_SRC = 9;

  localparam logic [7:0] OFS_SET  = 8'h08;
  localparam logic [7:0] OFS_CLR  = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_RAW  = 8'h2C;

  localparam int B_RX_TRIG  = 0;
  localparam int B_RX_EMPTY = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_EMPTY = 3;
  localparam int B_TX_FULL  = 4;
  localparam int B_OVERRUN  = 5;
  localparam int B_FRAMING  = 6;
  localparam int B_PARITY   = 7;
  localparam int B_TIMEOUT  = 8;

  typedef struct packed {
    logic set_wr;
    logic clr_wr;
    logic stat_wr;
    logic rd_en;
  } strobe_t;
endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam int CMP_W = (ADDR_W < 8) ? ADDR_W : 8;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    logic [ADDR_W-1:0] full;
    full = '0;
    full[CMP_W-1:0] = ofs[CMP_W-1:0];
    return a == full;
  endfunction

  always_comb begin
    stb.set_wr  = sel & wr & hit(addr, OFS_SET);
    stb.clr_wr  = sel & wr & hit(addr, OFS_CLR);
    stb.stat_wr = sel & wr & hit(addr, OFS_STAT);
    stb.rd_en   = sel & ~wr;
  end
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               set_wr,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (set_wr)
      mask_q <= mask_q | bits;
    else if (clr_wr)
      mask_q <= mask_q & ~bits;
  end

  // R2: ones written through the set alias are present afterwards
  p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((mask_q & $past(bits)) == $past(bits)));

  // R3: ones written through the clear alias are absent afterwards
  p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((mask_q & $past(bits)) == '0));
endmodule

// File: rtl/uirq_status_reg.sv
module uirq_status_reg
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] stat_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (evt[i])
        stat_q[i] <= 1'b1;
      else if (clr_wr && bits[i])
        stat_q[i] <= 1'b0;
    end
  end

  // R5 / R7: every pulse is captured, even against a same-cycle clear
  p_evt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

  // R6: cleared bits without a simultaneous event drop
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((stat_q & $past(bits & ~evt)) == '0));
endmodule

// File: rtl/uirq_bank.sv
module uirq_bank
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               lv_rx_trig,
  input  logic               lv_rx_empty,
  input  logic               lv_tx_empty,
  input  logic               lv_tx_full,
  output logic               irq
);
  localparam int CMP_W = (ADDR_W < 8) ? ADDR_W : 8;

  strobe_t            stb;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] rd_sel;

  assign wbits = bus_wdata[NUM_SRC-1:0];

  uirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel (bus_sel),
    .wr  (bus_wr),
    .addr(bus_addr),
    .stb (stb)
  );

  uirq_mask_reg u_mask (
    .clk   (clk),
    .rst   (rst),
    .set_wr(stb.set_wr),
    .clr_wr(stb.clr_wr),
    .bits  (wbits),
    .mask_q(mask_q)
  );

  uirq_status_reg u_stat (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .clr_wr(stb.stat_wr),
    .bits  (wbits),
    .stat_q(stat_q)
  );

  always_comb begin
    raw = '0;
    raw[B_RX_TRIG]  = lv_rx_trig;
    raw[B_RX_EMPTY] = lv_rx_empty;
    raw[B_TX_EMPTY] = lv_tx_empty;
    raw[B_TX_FULL]  = lv_tx_full;
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_MASK[CMP_W-1:0]))
      rd_sel = mask_q;
    else if (bus_addr == ADDR_W'(OFS_STAT[CMP_W-1:0]))
      rd_sel = stat_q;
    else if (bus_addr == ADDR_W'(OFS_RAW[CMP_W-1:0]))
      rd_sel = raw;
    else
      rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (stb.rd_en) begin
      rd_data <= '0;
      rd_data[NUM_SRC-1:0] <= rd_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= |(stat_q & mask_q);
  end

  // R8: the line reports the masked status of the previous cycle
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(stat_q) & $past(mask_q))));

  // R10: no read returns anything above the source bits
  p_hi_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/uirq_bank_test.sv
module uirq_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic [8:0]  evt = '0;
  logic        lv_rx_trig = 1'b0;
  logic        lv_rx_empty = 1'b0;
  logic        lv_tx_empty = 1'b0;
  logic        lv_tx_full = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uirq_bank uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .evt(evt), .lv_rx_trig(lv_rx_trig), .lv_rx_empty(lv_rx_empty),
    .lv_tx_empty(lv_tx_empty), .lv_tx_full(lv_tx_full), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [8:0] e = '0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt = e;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [8:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    rd(8'h10, d); check("R1 mask", d, 32'h0);
    rd(8'h14, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_mask_set();
    logic [31:0] d;
    wr(8'h08, 32'h05);
    rd(8'h10, d); check("R2 set", d, 32'h05);
    wr(8'h08, 32'h0);
    rd(8'h10, d); check("R2 zero write", d, 32'h05);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R10 set all", d, 32'h1FF);
  endtask

  task automatic t_mask_clr();
    logic [31:0] d;
    wr(8'h0C, 32'h101);
    rd(8'h10, d); check("R3 clear", d, 32'h0FE);
    wr(8'h0C, 32'h0);
    rd(8'h10, d); check("R3 zero write", d, 32'h0FE);
    rd(8'h08, d); check("R4 set alias reads 0", d, 32'h0);
    rd(8'h0C, d); check("R4 clr alias reads 0", d, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h10, d); check("R4 mask read-only", d, 32'h0FE);
    wr(8'h0C, 32'h1FF);
    rd(8'h10, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(9'h0A0);
    idle(1);
    check("R8 masked no irq", {31'b0, irq}, 32'h0);
    rd(8'h14, d); check("R5 latch masked", d, 32'h0A0);
    idle(3);
    rd(8'h14, d); check("R5 sticky", d, 32'h0A0);
    wr(8'h08, 32'h020);
    idle(1);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h14, d); check("R6 zero write", d, 32'h0A0);
    wr(8'h14, 32'hFFFF_FE20);
    rd(8'h14, d); check("R6 clear one", d, 32'h080);
    check("R8 irq off", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h080);
    rd(8'h14, d); check("R6 clear rest", d, 32'h0);
    wr(8'h0C, 32'h1FF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(9'h001);
    wr(8'h14, 32'h041, 9'h040);
    rd(8'h14, d); check("R7 event beats clear", d, 32'h040);
    wr(8'h14, 32'h040);
    rd(8'h14, d); check("R7 later clear", d, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    @(negedge clk);
    lv_rx_trig = 1'b1; lv_tx_full = 1'b1;
    rd(8'h2C, d); check("R9 raw trig/full", d, 32'h11);
    @(negedge clk);
    lv_rx_trig = 1'b0; lv_tx_full = 1'b0; lv_rx_empty = 1'b1; lv_tx_empty = 1'b1;
    rd(8'h2C, d); check("R9 raw empties", d, 32'h0A);
    rd(8'h14, d); check("R9 raw not latched", d, 32'h0);
    rd(8'h18, d); check("R11 unmapped", d, 32'h0);
    check("R11 rd_data holds", rd_data, 32'h0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_mask_set();
        t_mask_clr();
        t_events();
        t_collide();
        t_raw();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule